// File: doc/BRIEF.md
# Reloading Timer/Event Counter Channel

This block is one 16-bit counting channel of a microcontroller-style peripheral. It has two modes. In timer mode it decrements once for every cycle on which a prescaled clock-enable input is high. In event mode it counts the rising edges of an external strobe, which passes through a synchronizer first. A direction input selects whether each edge counts up or down.

When a count step passes below zero or above the maximum, the counter loads a stored preset instead of wrapping. It also issues a one-cycle interrupt request.

Software drives the block over a small register bus with four word addresses:
- a control word holding the start bit;
- a mode word;
- a combined count/preset word;
- a status word with a sticky error flag.

Software sets the mode and the preset while the channel is stopped, then sets the start bit. Configuration writes made while the channel is running are discarded and flagged. For one cycle after each reload, a count read returns a fixed sentinel value instead of the reloaded value.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset the start bit, mode, count readback, error flag and `irq` are all 0.
- R2: The start bit is bit 0 of address 0. Writing 1 to it while it is 0 loads the preset into the counter. Counting happens only while the start bit is 1.
- R3: In timer mode (address 1, bit 0 = 0) the counter decreases by 1 on each cycle with `tick_en` high, and `dir_up` has no effect.
- R4: In event mode (address 1, bit 0 = 1) each rising edge of `evt_in` is synchronized through two flops and steps the counter once. The step is up when `dir_up` is 1 and down when it is 0. `tick_en` has no effect in this mode.
- R5: A down step from 0000h, or an up step from FFFFh, loads the preset. Each such reload drives `irq` high for exactly the next cycle.
- R6: In the cycle right after a reload, a read of address 2 returns FFFFh after an underflow and 0000h after an overflow. From the following cycle on, it returns the live count.
- R7: A write to address 2 while stopped stores the preset. The written value reads back unchanged from address 2 until the channel is started.
- R8: While running, writes to address 1 or address 2 are discarded and set the error flag (address 3, bit 0). Writing 1 to that bit clears the flag.
- R9: Clearing the start bit freezes the count. While stopped there is no step, no reload and no `irq`.
- R10: While running, a read of address 2 outside the reload cycle returns the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Word address: 0 control, 1 mode, 2 count/preset, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Prescaled count enable for timer mode |
| evt_in | input | 1 | Asynchronous external event strobe |
| dir_up | input | 1 | Event mode direction: 1 up, 0 down |
| irq | output | 1 | One-cycle pulse after each reload |

## Verification
The sentinel reads are the hardest behaviour to reach. They exist for a single cycle, and only after a step taken exactly at a count limit. For event-mode overflow, that cycle comes several edges after the strobe rises, because of the synchronizer and the edge detector.

To reach it, the stimulus programs presets at or next to 0000h and FFFFh. It holds the read address on the count word and samples the reload cycle at a computed offset from the stimulus edge: one cycle after a timer tick, three cycles after an event strobe rises. It then reads again one cycle later to confirm the reloaded value.

Discarded writes during counting are detected through the count, mode and status reads that follow them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
   localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;
   localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;
   typedef enum logic {MODE_TIMER = 1'b0, MODE_EVENT = 1'b1} rtc_mode_e;
endpackage

// File: rtl/rtc_evt_sync.sv
module rtc_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rtc_evt_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   input  logic [W-1:0]      cnt_view,
   output logic              run_o,
   output rtc_mode_e         mode_o,
   output logic [W-1:0]      preset_o,
   output logic              err_o,
   output logic              start_pulse_o,
   output logic              preset_we_o,
   output logic [W-1:0]      bus_rdata
);
   localparam logic [W-2:0] PAD = '0;

   logic we;
   logic cfg_busy;

   assign we            = bus_sel & bus_wr;
   assign cfg_busy      = we & run_o & (bus_addr == A_MODE || bus_addr == A_COUNT);
   assign start_pulse_o = we & (bus_addr == A_CTRL) & bus_wdata[0] & ~run_o;
   assign preset_we_o   = we & (bus_addr == A_COUNT) & ~run_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         mode_o   <= MODE_TIMER;
         preset_o <= '0;
         err_o    <= 1'b0;
      end else begin
         if (we && bus_addr == A_CTRL) run_o <= bus_wdata[0];
         if (we && bus_addr == A_MODE && !run_o) mode_o <= rtc_mode_e'(bus_wdata[0]);
         if (preset_we_o) preset_o <= bus_wdata;
         if (cfg_busy) err_o <= 1'b1;
         else if (we && bus_addr == A_STAT && bus_wdata[0]) err_o <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = {PAD, run_o};
         A_MODE:  bus_rdata = {PAD, mode_o};
         A_COUNT: bus_rdata = cnt_view;
         default: bus_rdata = {PAD, err_o};
      endcase
   end
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         step,
   input  logic         up,
   input  logic         start_pulse,
   input  logic         preset_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] preset,
   output logic [W-1:0] count_o,
   output logic         irq_o,
   output logic [W-1:0] view_o
);
   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] CNT_MIN = '0;

   logic reload_q;
   logic ovf_q;
   logic at_limit;

   assign at_limit = up ? (count_o == CNT_MAX) : (count_o == CNT_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o  <= '0;
         reload_q <= 1'b0;
         ovf_q    <= 1'b0;
         irq_o    <= 1'b0;
      end else begin
         reload_q <= 1'b0;
         irq_o    <= 1'b0;
         if (preset_we) begin
            count_o <= wdata;
         end else if (start_pulse) begin
            count_o <= preset;
         end else if (run && step) begin
            if (at_limit) begin
               count_o  <= preset;
               reload_q <= 1'b1;
               ovf_q    <= up;
               irq_o    <= 1'b1;
            end else if (up) begin
               count_o <= count_o + 1'b1;
            end else begin
               count_o <= count_o - 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (reload_q) view_o = ovf_q ? CNT_MIN : CNT_MAX;
      else          view_o = count_o;
   end
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
   import rtc_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              tick_en,
   input  logic              evt_in,
   input  logic              dir_up,
   output logic              irq
);
   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("reload_timer_chan: WIDTH out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("reload_timer_chan: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             run_q;
   rtc_mode_e        mode_q;
   logic [WIDTH-1:0] preset_q;
   logic             err_q;
   logic             start_pulse;
   logic             preset_we;
   logic [WIDTH-1:0] count_q;
   logic [WIDTH-1:0] cnt_view;
   logic             evt_rise;
   logic             step;
   logic             up;

   rtc_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (evt_in),
      .rise_o   (evt_rise)
   );

   always_comb begin
      if (mode_q == MODE_EVENT) begin
         step = evt_rise;
         up   = dir_up;
      end else begin
         step = tick_en;
         up   = 1'b0;
      end
   end

   rtc_regs #(.W(WIDTH)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_sel       (bus_sel),
      .bus_wr        (bus_wr),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .cnt_view      (cnt_view),
      .run_o         (run_q),
      .mode_o        (mode_q),
      .preset_o      (preset_q),
      .err_o         (err_q),
      .start_pulse_o (start_pulse),
      .preset_we_o   (preset_we),
      .bus_rdata     (bus_rdata)
   );

   rtc_core #(.W(WIDTH)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run_q),
      .step        (step),
      .up          (up),
      .start_pulse (start_pulse),
      .preset_we   (preset_we),
      .wdata       (bus_wdata),
      .preset      (preset_q),
      .count_o     (count_q),
      .irq_o       (irq),
      .view_o      (cnt_view)
   );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
   import rtc_pkg::*;
#(
   parameter int W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              run_q,
   input logic              start_pulse,
   input logic              preset_we,
   input logic              step,
   input logic              up,
   input logic [W-1:0]      count_q,
   input logic [W-1:0]      preset_q,
   input logic [W-1:0]      cnt_view,
   input logic              mode_q,
   input logic              err_q,
   input logic              irq
);
   assert_irq_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(run_q));

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> (count_q == $past(preset_q)));

   assert_frozen_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start_pulse && !preset_we) |=> $stable(count_q));

   assert_underflow_sentinel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && step && !up && count_q == '0) |=> (cnt_view == '1 && irq));

   assert_overflow_sentinel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && step && up && count_q == '1) |=> (cnt_view == '0 && irq));

   assert_busy_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && run_q && (bus_addr == A_MODE || bus_addr == A_COUNT)) |=> err_q);

   assert_busy_mode_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && run_q && bus_addr == A_MODE) |=> $stable(mode_q));
endmodule

bind reload_timer_chan rtc_checker #(.W(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .run_q       (run_q),
   .start_pulse (start_pulse),
   .preset_we   (preset_we),
   .step        (step),
   .up          (up),
   .count_q     (count_q),
   .preset_q    (preset_q),
   .cnt_view    (cnt_view),
   .mode_q      (mode_q),
   .err_q       (err_q),
   .irq         (irq)
);

// File: tb/reload_timer_chan_bench.sv
module reload_timer_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        tick_en = 1'b0;
   logic        evt_in = 1'b0;
   logic        dir_up = 1'b0;
   logic        irq;

   int nchk = 0;
   int nerr = 0;
   int irq_seen = 0;

   always #10 clk = ~clk;

   reload_timer_chan u_reload_timer_chan (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_en(tick_en), .evt_in(evt_in), .dir_up(dir_up), .irq(irq)
   );

   always @(negedge clk) if (irq) irq_seen++;

   // fields: mode, dir, preset, steps, expected count, expected irq pulses
   localparam logic [49:0] VEC [8] = '{
      {1'b0, 1'b0, 16'd5,     8'd3, 16'd2,     8'd0},
      {1'b0, 1'b0, 16'd2,     8'd3, 16'd2,     8'd1},
      {1'b0, 1'b0, 16'd0,     8'd4, 16'd0,     8'd4},
      {1'b0, 1'b1, 16'd1,     8'd2, 16'd1,     8'd1},
      {1'b1, 1'b1, 16'hFFFD,  8'd2, 16'hFFFF,  8'd0},
      {1'b1, 1'b1, 16'hFFFE,  8'd3, 16'hFFFF,  8'd1},
      {1'b1, 1'b0, 16'd3,     8'd5, 16'd2,     8'd1},
      {1'b1, 1'b0, 16'd0,     8'd2, 16'd0,     8'd2}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic tick();
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
   endtask

   task automatic evt();
      evt_in = 1'b1;
      repeat (5) @(negedge clk);
      evt_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
      rd(2'd1, d); check("R1 mode", d, 16'h0000);
      rd(2'd2, d); check("R1 count", d, 16'h0000);
      rd(2'd3, d); check("R1 status", d, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);
      // R2 never started: ticks do nothing
      tick(); tick();
      rd(2'd2, d); check("R2 no count before start", d, 16'h0000);

      // table walk: R3 R4 R5 R10 R7
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, 16'd0);
         wr(2'd1, {15'd0, VEC[i][49]});
         wr(2'd2, VEC[i][47:32]);
         rd(2'd2, d); check("R7 preset readback", d, VEC[i][47:32]);
         dir_up = VEC[i][48];
         wr(2'd0, 16'd1);
         irq_seen = 0;
         for (int k = 0; k < int'(VEC[i][31:24]); k++) begin
            if (VEC[i][49]) evt(); else tick();
         end
         @(negedge clk);
         rd(2'd2, d);
         check(VEC[i][49] ? "R4 R10 event count" : "R3 R10 timer count", d, VEC[i][23:8]);
         check("R5 irq pulses", 16'(irq_seen), {8'd0, VEC[i][7:0]});
      end

      // R6 underflow sentinel in timer mode
      wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd1); wr(2'd0, 16'd1);
      bus_addr = 2'd2;
      tick();
      tick();
      rd(2'd2, d); check("R6 underflow sentinel", d, 16'hFFFF);
      check("R5 irq in reload cycle", {15'd0, irq}, 16'h0001);
      @(negedge clk);
      rd(2'd2, d); check("R6 after sentinel", d, 16'h0001);
      check("R5 irq one cycle", {15'd0, irq}, 16'h0000);

      // R6 overflow sentinel in event mode
      wr(2'd0, 16'd0); wr(2'd1, 16'd1); wr(2'd2, 16'hFFFF);
      dir_up = 1'b1;
      wr(2'd0, 16'd1);
      bus_addr = 2'd2;
      evt_in = 1'b1;
      repeat (3) @(negedge clk);
      rd(2'd2, d); check("R6 overflow sentinel", d, 16'h0000);
      @(negedge clk);
      rd(2'd2, d); check("R6 after overflow", d, 16'hFFFF);
      evt_in = 1'b0;
      repeat (4) @(negedge clk);

      // R4 tick_en ignored in event mode
      tick(); tick();
      rd(2'd2, d); check("R4 tick ignored in event mode", d, 16'hFFFF);

      // R8 writes while running are discarded and flagged
      wr(2'd2, 16'h1234);
      rd(2'd2, d); check("R8 count kept", d, 16'hFFFF);
      rd(2'd3, d); check("R8 error set", d, 16'h0001);
      wr(2'd1, 16'd0);
      rd(2'd1, d); check("R8 mode kept", d, 16'h0001);
      wr(2'd3, 16'd1);
      rd(2'd3, d); check("R8 error cleared", d, 16'h0000);

      // R9 freeze on stop, R2 restart reloads preset
      wr(2'd0, 16'd0); wr(2'd1, 16'd0); wr(2'd2, 16'd3); wr(2'd0, 16'd1);
      tick();
      wr(2'd0, 16'd0);
      irq_seen = 0;
      tick(); tick(); tick(); tick();
      rd(2'd2, d); check("R9 frozen count", d, 16'h0002);
      wr(2'd2, 16'd0);
      tick(); tick();
      rd(2'd2, d); check("R9 stopped at zero no step", d, 16'h0000);
      check("R9 no irq while stopped", 16'(irq_seen), 16'd0);
      wr(2'd2, 16'd3);
      rd(2'd3, d); check("R8 no error when stopped", d, 16'h0000);
      tick(); wr(2'd0, 16'd1);
      rd(2'd2, d); check("R2 start loads preset", d, 16'h0003);
      tick();
      rd(2'd2, d); check("R2 R10 counting after start", d, 16'h0002);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule